// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Extract and Insert

This block handles the signaling nibbles of the 30 voice channels of an E1 line. Those nibbles travel in timeslot 16 across a 16-frame signaling multiframe. On the receive side, a framer hands the block the eight timeslot-16 bits of each frame as a bit stream, together with the frame's position in the multiframe. The block assembles each byte and files it in one of 16 byte-wide receive signaling registers. On the transmit side, a host fills 16 transmit signaling registers. At the start of each frame the block takes a snapshot of the register for that frame and streams it out as the frame's timeslot-16 bits.

Two channels share each register. For frames 1 to 15, the high nibble of the register for frame n carries bits A, B, C and D of channel n. Channel n lives in timeslot n, so channels 1..15 use timeslots 1..15. The low nibble carries channel n+15, which lives in timeslot n+16 and so covers timeslots 17..31. Timeslots 0 and 16 carry no channel. The register for frame 0 holds the multiframe alignment word, whose high nibble is always sent as 0000.

Both bit streams use valid/ready. The receive stream never pushes back: `rx_ready` is always high, and a bit is taken on every cycle in which `rx_valid` is high. The transmit stream honours back-pressure: while `tx_ready` is low, `tx_valid` and `tx_bit` stay put. A bit moves only on a cycle where both are high. Multiframe alignment search and alarm handling belong to the framer, not to this block.

Top module: `e1_cas_sig`

## Requirements
- R1: After reset, every receive register reads 0x00, every transmit register reads 0xFF, `tx_valid` is 0 and `host_rdata` is 0x00.
- R2: A receive byte begins on an accepted bit with `rx_first`=1. Eight accepted bits form the byte, MSB first. The byte is stored in the receive register indexed by the `rx_frame` value sampled on that first bit. It can be read in the cycle after the eighth bit is accepted. `rx_ready` is always 1.
- R3: For frames 1..15, register n holds ABCD of channel n in bits 7:4 and ABCD of channel n+15 in bits 3:0, with A as the most significant bit of each nibble. Register 0 belongs to frame 0 on both sides.
- R4: A byte whose eighth bit arrives while `cas_sync`=0 is discarded, and the register keeps its previous value.
- R5: Host writes to addresses 0..15 (the receive side) have no effect.
- R6: `host_addr[4]`=0 selects receive register `host_addr[3:0]`, and 1 selects transmit register `host_addr[3:0]`. A read (`host_cs`=1, `host_we`=0) places data on `host_rdata` one cycle later. Otherwise `host_rdata` holds its value.
- R7: A `tx_start` pulse loads the transmit register for `tx_frame`. From the next cycle, `tx_valid` stays high for exactly eight transfers, which present the byte MSB first.
- R8: While `tx_valid`=1 and `tx_ready`=0, `tx_bit` and `tx_valid` hold steady.
- R9: A host write to a transmit register after `tx_start` does not change the byte being sent. It first takes effect at the next `tx_start`.
- R10: For frame 0, the transmitted high nibble is forced to 0000, and the low nibble comes from transmit register 0.
- R11: Bits accepted with no byte in progress (and without `rx_first`) are ignored. An `rx_first` bit in the middle of a byte abandons the partial byte and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive timeslot-16 bit valid |
| rx_ready | output | 1 | Receive ready, always 1 |
| rx_bit | input | 1 | Receive timeslot-16 bit |
| rx_first | input | 1 | Marks the MSB of a frame's timeslot 16 |
| rx_frame | input | 4 | Receive frame number within the multiframe |
| cas_sync | input | 1 | Signaling multiframe alignment is valid |
| tx_start | input | 1 | Start of transmit frame; loads the snapshot |
| tx_frame | input | 4 | Transmit frame number within the multiframe |
| tx_valid | output | 1 | Transmit bit valid |
| tx_ready | input | 1 | Transmit consumer ready |
| tx_bit | output | 1 | Transmit timeslot-16 bit, MSB first |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable |
| host_addr | input | 5 | Bit 4 selects the side, bits 3:0 the register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |

## Verification
A received byte lands in its register at the clock edge that accepts its eighth bit. The bench drives bits on falling edges and reads the register back with a host read issued at the following falling edge. A host read returns data one edge after the strobe, so the bench samples `host_rdata` on the falling edge after the read is issued. The first transmit bit appears one edge after `tx_start`, and each later bit appears one edge after a transfer. The bench therefore reads `tx_bit` on falling edges, holds `tx_ready` low for whole cycles to check that the bit stays put, and confirms that `tx_valid` drops right after the eighth transfer.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  // side select carried in the top address bit of the host bus
  typedef enum logic {SIDE_RX = 1'b0, SIDE_TX = 1'b1} side_e;

  // frame 0 carries the multiframe alignment pattern in its upper nibble
  function automatic logic [7:0] mf_fix(input logic [7:0] word, input logic is_frame0);
    mf_fix = is_frame0 ? {4'b0000, word[3:0]} : word;
  endfunction
endpackage

// File: rtl/e1cas_rx_asm.sv
module e1cas_rx_asm #(
  parameter int SLOT_W  = 8,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_bit,
  input  logic               in_first,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               mf_sync,
  output logic               wr_en,
  output logic [FRAME_W-1:0] wr_idx,
  output logic [SLOT_W-1:0]  wr_data
);
  localparam int CNT_W = $clog2(SLOT_W + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [SLOT_W-1:0]  sh_q;
  logic [FRAME_W-1:0] frame_q;
  logic               take;
  logic               last;
  logic [SLOT_W-1:0]  sh_nxt;

  always_comb begin
    take   = in_valid && (in_first || (cnt_q != '0));
    sh_nxt = in_first ? {{(SLOT_W-1){1'b0}}, in_bit} : {sh_q[SLOT_W-2:0], in_bit};
    last   = take && !in_first && (cnt_q == CNT_W'(SLOT_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      frame_q <= '0;
    end else if (take) begin
      sh_q <= sh_nxt;
      if (in_first) begin
        cnt_q   <= CNT_W'(1);
        frame_q <= in_frame;
      end else if (last) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign wr_en   = last && mf_sync;
  assign wr_idx  = frame_q;
  assign wr_data = sh_nxt;
endmodule

// File: rtl/e1cas_regbank.sv
module e1cas_regbank
  import e1cas_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SLOT_W = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_we,
  input  logic [IDX_W-1:0]             rx_idx,
  input  logic [SLOT_W-1:0]            rx_wdata,
  input  logic                         host_cs,
  input  logic                         host_we,
  input  logic [IDX_W:0]               host_addr,
  input  logic [SLOT_W-1:0]            host_wdata,
  output logic [SLOT_W-1:0]            host_rdata,
  input  logic [IDX_W-1:0]             tx_idx,
  output logic [SLOT_W-1:0]            tx_word,
  output logic [DEPTH-1:0][SLOT_W-1:0] rx_view
);
  logic [DEPTH-1:0][SLOT_W-1:0] rx_mem;
  logic [DEPTH-1:0][SLOT_W-1:0] tx_mem;
  side_e                        side;
  logic [IDX_W-1:0]             hidx;

  assign side = side_e'(host_addr[IDX_W]);
  assign hidx = host_addr[IDX_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) rx_mem[g] <= '0;
      else if (rx_we && rx_idx == IDX_W'(g)) rx_mem[g] <= rx_wdata;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) tx_mem[g] <= '1;
      else if (host_cs && host_we && side == SIDE_TX && hidx == IDX_W'(g))
        tx_mem[g] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_cs && !host_we)
      host_rdata <= (side == SIDE_TX) ? tx_mem[hidx] : rx_mem[hidx];
  end

  assign tx_word = tx_mem[tx_idx];
  assign rx_view = rx_mem;
endmodule

// File: rtl/e1cas_tx_ser.sv
module e1cas_tx_ser
  import e1cas_pkg::*;
#(
  parameter int SLOT_W  = 8,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [SLOT_W-1:0]  word,
  input  logic               ready,
  output logic               valid,
  output logic               bit_out
);
  localparam int CNT_W = $clog2(SLOT_W + 1);

  logic [SLOT_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (start) begin
      sh_q   <= mf_fix(word, frame == '0);
      left_q <= CNT_W'(SLOT_W);
    end else if (valid && ready) begin
      sh_q   <= {sh_q[SLOT_W-2:0], 1'b0};
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign valid   = (left_q != '0);
  assign bit_out = sh_q[SLOT_W-1];
endmodule

// File: rtl/e1_cas_sig.sv
module e1_cas_sig #(
  parameter int FRAMES  = 16,
  parameter int SLOT_W  = 8,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic               rx_bit,
  input  logic               rx_first,
  input  logic [FRAME_W-1:0] rx_frame,
  input  logic               cas_sync,
  input  logic               tx_start,
  input  logic [FRAME_W-1:0] tx_frame,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic               tx_bit,
  input  logic               host_cs,
  input  logic               host_we,
  input  logic [FRAME_W:0]   host_addr,
  input  logic [SLOT_W-1:0]  host_wdata,
  output logic [SLOT_W-1:0]  host_rdata
);
  logic                         rx_wr_en;
  logic [FRAME_W-1:0]           rx_wr_idx;
  logic [SLOT_W-1:0]            rx_wr_data;
  logic [SLOT_W-1:0]            tx_word;
  logic [FRAMES-1:0][SLOT_W-1:0] rx_view;

  assign rx_ready = 1'b1;

  e1cas_rx_asm #(.SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_bit(rx_bit),
    .in_first(rx_first), .in_frame(rx_frame), .mf_sync(cas_sync),
    .wr_en(rx_wr_en), .wr_idx(rx_wr_idx), .wr_data(rx_wr_data)
  );

  e1cas_regbank #(.DEPTH(FRAMES), .SLOT_W(SLOT_W), .IDX_W(FRAME_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .rx_we(rx_wr_en), .rx_idx(rx_wr_idx),
    .rx_wdata(rx_wr_data), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_idx(tx_frame), .tx_word(tx_word), .rx_view(rx_view)
  );

  e1cas_tx_ser #(.SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .frame(tx_frame),
    .word(tx_word), .ready(tx_ready), .valid(tx_valid), .bit_out(tx_bit)
  );
endmodule

// File: rtl/e1_cas_sig_chk.sv
module e1_cas_sig_chk #(
  parameter int FRAMES  = 16,
  parameter int SLOT_W  = 8,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cas_sync,
  input logic                          rx_wr_en,
  input logic [FRAMES-1:0][SLOT_W-1:0] rx_view,
  input logic                          tx_start,
  input logic [FRAME_W-1:0]            tx_frame,
  input logic                          tx_valid,
  input logic                          tx_ready,
  input logic                          tx_bit,
  input logic                          host_cs,
  input logic                          host_we,
  input logic [SLOT_W-1:0]             host_rdata
);
  assert_sync_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en |-> cas_sync);

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_wr_en |=> $stable(rx_view));

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_cs && !host_we) |=> $stable(host_rdata));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_valid);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_start) |=> (tx_valid && $stable(tx_bit)));

  assert_mfas_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_frame == '0) |=> !tx_bit);
endmodule

bind e1_cas_sig e1_cas_sig_chk #(.FRAMES(FRAMES), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_sync(cas_sync), .rx_wr_en(rx_wr_en),
  .rx_view(rx_view), .tx_start(tx_start), .tx_frame(tx_frame),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
  .host_cs(host_cs), .host_we(host_we), .host_rdata(host_rdata)
);

// File: tb/e1_cas_sig_test.sv
module e1_cas_sig_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_valid = 0, rx_bit = 0, rx_first = 0, cas_sync = 1;
  logic [3:0] rx_frame = 0;
  logic       rx_ready;
  logic       tx_start = 0, tx_ready = 1;
  logic [3:0] tx_frame = 0;
  logic       tx_valid, tx_bit;
  logic       host_cs = 0, host_we = 0;
  logic [4:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  e1_cas_sig uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_cs = 0; host_we = 0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); host_cs = 1; host_we = 0; host_addr = a;
    @(negedge clk); host_cs = 0; d = host_rdata;
  endtask

  task automatic rx_send(input logic [3:0] f, input logic [7:0] b, input bit syn,
                         input int nbits, input bit with_first);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_first = with_first && (i == 0);
      rx_bit = b[7 - (i % 8)]; rx_frame = f; cas_sync = syn;
    end
    @(negedge clk); rx_valid = 0; rx_first = 0; cas_sync = 1;
  endtask

  // sends one frame; stall inserts one ready-low cycle before each bit,
  // wr_mid writes reg 16+f mid-frame
  task automatic tx_get(input logic [3:0] f, input bit stall, input bit wr_mid,
                        output logic [7:0] got);
    @(negedge clk); tx_start = 1; tx_frame = f; tx_ready = 1;
    @(negedge clk); tx_start = 0;
    got = 0;
    for (int i = 0; i < 8; i++) begin
      if (stall) begin
        logic held;
        held = tx_bit; tx_ready = 0;
        @(negedge clk);
        chk(tx_valid && tx_bit == held, "R8 stall hold", tx_bit, held);
        tx_ready = 1;
      end
      chk(tx_valid, "R7 valid during frame", tx_valid, 1);
      got = {got[6:0], tx_bit};
      if (wr_mid && i == 3) begin
        host_cs = 1; host_we = 1; host_addr = {1'b1, f}; host_wdata = 8'h5A;
      end
      @(negedge clk);
      host_cs = 0; host_we = 0;
    end
    chk(!tx_valid, "R7 valid drops after 8", tx_valid, 0);
  endtask

  function automatic logic [7:0] rx_pat(input int f, input int seed);
    return 8'((f * 29 + 7 + seed * 53) & 8'hFF);
  endfunction

  function automatic logic [7:0] tx_pat(input int f);
    return 8'((f * 71 + 19) & 8'hFF);
  endfunction

  initial begin
    logic [7:0] d, g;
    logic [7:0] rxv [16];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid, "R1 tx_valid reset", tx_valid, 0);
    chk(host_rdata == 8'h00, "R1 rdata reset", host_rdata, 0);
    chk(rx_ready, "R2 rx_ready", rx_ready, 1);
    for (int f = 0; f < 16; f++) begin
      hread(5'(f), d);      chk(d == 8'h00, "R1 rx reg reset", d, 0);
      hread(5'(16 + f), d); chk(d == 8'hFF, "R1 tx reg reset", d, 8'hFF);
    end

    // R2/R3: sweep all frames on receive
    for (int f = 0; f < 16; f++) rx_send(4'(f), rx_pat(f, 0), 1, 8, 1);
    for (int f = 0; f < 16; f++) begin
      hread(5'(f), d); rxv[f] = d;
      chk(d == rx_pat(f, 0), "R2 rx byte stored", d, rx_pat(f, 0));
    end
    for (int c = 1; c <= 30; c++) begin
      int fr = (c <= 15) ? c : c - 15;
      logic [3:0] exp_n = (c <= 15) ? rx_pat(fr, 0)[7:4] : rx_pat(fr, 0)[3:0];
      logic [3:0] act_n = (c <= 15) ? rxv[fr][7:4] : rxv[fr][3:0];
      chk(act_n == exp_n, "R3 channel nibble", act_n, exp_n);
    end

    // R2: immediate read after eighth bit
    rx_send(4'd9, 8'hC3, 1, 8, 1);
    hread(5'd9, d); chk(d == 8'hC3, "R2 immediate readback", d, 8'hC3);

    // R4: sync low discards
    for (int f = 0; f < 16; f++) rx_send(4'(f), rx_pat(f, 1), 0, 8, 1);
    for (int f = 0; f < 16; f++) begin
      hread(5'(f), d);
      g = (f == 9) ? 8'hC3 : rx_pat(f, 0);
      chk(d == g, "R4 no update without sync", d, g);
    end

    // R5: rx writes ignored
    hwrite(5'd4, 8'hEE);
    hread(5'd4, d); chk(d == rx_pat(4, 0), "R5 rx write ignored", d, rx_pat(4, 0));

    // R11: stray bits ignored, rx_first restarts
    rx_send(4'd6, 8'hFF, 1, 8, 0);
    hread(5'd6, d); chk(d == rx_pat(6, 0), "R11 stray bits ignored", d, rx_pat(6, 0));
    rx_send(4'd6, 8'hF0, 1, 3, 1);
    rx_send(4'd6, 8'h69, 1, 8, 1);
    hread(5'd6, d); chk(d == 8'h69, "R11 restart on first", d, 8'h69);

    // R6/R7/R10: transmit sweep
    for (int f = 0; f < 16; f++) hwrite(5'(16 + f), tx_pat(f));
    for (int f = 0; f < 16; f++) begin
      hread(5'(16 + f), d); chk(d == tx_pat(f), "R6 tx readback", d, tx_pat(f));
    end
    for (int f = 0; f < 16; f++) begin
      tx_get(4'(f), 0, 0, g);
      d = (f == 0) ? {4'h0, tx_pat(0)[3:0]} : tx_pat(f);
      chk(g == d, (f == 0) ? "R10 frame0 word" : "R7 tx byte", g, d);
    end

    // R8: back-pressure
    tx_get(4'd3, 1, 0, g); chk(g == tx_pat(3), "R8 byte under stall", g, tx_pat(3));
    tx_get(4'd0, 1, 0, g); chk(g == {4'h0, tx_pat(0)[3:0]}, "R10 frame0 under stall", g, {4'h0, tx_pat(0)[3:0]});

    // R9: mid-frame write
    tx_get(4'd7, 0, 1, g); chk(g == tx_pat(7), "R9 snapshot kept", g, tx_pat(7));
    tx_get(4'd7, 0, 0, g); chk(g == 8'h5A, "R9 next frame new", g, 8'h5A);

    // R6: rdata holds without read
    hread(5'd17, d);
    repeat (3) @(negedge clk);
    chk(host_rdata == tx_pat(1), "R6 rdata holds", host_rdata, tx_pat(1));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule